// File: doc/BRIEF.md
# I2C Target with Bounded Transfer Buffers

This block is a 7-bit-address I2C target that serves a single bus controller. A fast system clock samples SCL and SDA. The block detects start and stop conditions and compares the first byte after each start with its own address, which defaults to 0x55. On a write, each data byte goes into a receive buffer. On a read, bytes are shifted out of a transmit buffer that the host loaded beforehand. SDA is open-drain: the block only ever pulls it low, and it never holds SCL low.

Each buffer has a fixed depth. The depth is a parameter with a maximum of 255. On a write, bytes that arrive once the receive buffer is full are still acknowledged, but they are thrown away. On a read, the transfer ends when the controller sends a NACK or when the limit is reached. The block then lets go of SDA and clocks out nothing more. On a stop that closes an addressed session, the block posts an outcome code and a byte count and pulses a done flag for one cycle. The host side is a write port into the transmit buffer, a read port on the receive buffer, and the status outputs.

Top module: `i2c_buffered_target`

## Requirements
- R1: After reset SDA is released, `status_code` is 0, `status_count` is 0 and `status_done` is low.
- R2: The seven upper bits of the first byte after a start are compared with the own address (default 0x55). On a match SDA is pulled low for the ninth clock. On a mismatch nothing is acknowledged, the rest of that transfer is ignored, the status stays unchanged and no done pulse occurs.
- R3: With bit 0 of the address byte at 0 (controller writes), each data byte is taken MSB first. Bytes are stored at receive index 0, 1, 2 and so on, and each one is acknowledged.
- R4: On a write, once DEPTH bytes are stored, any further bytes are acknowledged but not stored. The session is then marked as overrun, and the count stays at DEPTH.
- R5: With bit 0 of the address byte at 1 (controller reads), transmit bytes go out MSB first from index 0 upward. Each bit is valid while SCL is high. The first bit follows the address acknowledge.
- R6: A controller NACK after a transmitted byte makes the block release SDA for the rest of the transfer, so further bytes read as 0xFF. The count includes the byte that was NACKed.
- R7: When the controller acknowledges transmitted byte number DEPTH, the block releases SDA instead of sending more. The session is marked as overrun.
- R8: A stop after an addressed session pulses `status_done` for exactly one cycle. It posts `status_code` 1 (write done), 2 (read done) or 3 (overrun), with `status_count` equal to the data bytes moved.
- R9: An addressed session that moves no data byte posts `status_code` 0 with count 0 at its stop.
- R10: The block changes its SDA drive only HOLD_CYC system cycles after a synchronized SCL fall. SDA never changes while SCL is high.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. SDA changes while SCL is low are data, not conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_drive_low | output | 1 | Pull SDA low when 1 (open-drain enable) |
| tx_wr_en | input | 1 | Host write strobe for the transmit buffer |
| tx_wr_idx | input | IDX_W | Transmit buffer entry to write |
| tx_wr_byte | input | 8 | Byte written to the transmit buffer |
| rx_rd_idx | input | IDX_W | Receive buffer entry to read |
| rx_rd_byte | output | 8 | Receive buffer entry content (combinational) |
| status_code | output | 2 | 0 busy/no data, 1 write done, 2 read done, 3 overrun |
| status_count | output | CNT_W | Data bytes moved in the last session |
| status_done | output | 1 | One-cycle pulse when a session closes |

## Verification
Every bus input passes two synchronizer flops and an edge register. A new SDA drive value therefore appears about HOLD_CYC plus three system cycles after SCL falls. The bench holds each SCL phase for 30 cycles and reads SDA twice in each high phase: 3 cycles after the rise and again just before the fall. This checks both that the value is there in time and that it stays stable. The status and the done pulse settle about four cycles after SDA rises for a stop, and the bench waits ten cycles before it reads them. The done pulses are counted on falling clock edges, and each scenario compares that count before and after its stop.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [1:0] {
    ST_BUSY    = 2'd0,
    ST_RX_DONE = 2'd1,
    ST_TX_DONE = 2'd2,
    ST_OVERRUN = 2'd3
  } tgt_status_e;

  typedef enum logic [2:0] {
    M_IDLE,
    M_ADDR,
    M_RX,
    M_TX,
    M_DRAIN
  } tgt_mode_e;

  // Address byte carries the 7-bit address in its upper bits.
  function automatic logic addr_hit(input logic [7:0] first_byte,
                                    input logic [6:0] own_addr);
    return first_byte[7:1] == own_addr;
  endfunction

  // Outcome posted at stop for an addressed session.
  function automatic tgt_status_e outcome(input logic overrun,
                                          input logic is_read,
                                          input logic any_data);
    if (!any_data)   return ST_BUSY;
    else if (overrun) return ST_OVERRUN;
    else if (is_read) return ST_TX_DONE;
    else              return ST_RX_DONE;
  endfunction

endpackage

// File: rtl/i2c_tgt_sampler.sv
module i2c_tgt_sampler #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [1:0] pins_raw;
  logic [1:0] pins_s;
  logic       scl_q;
  logic       sda_q;

  assign pins_raw = {scl_i, sda_i};

  for (genvar l = 0; l < 2; l++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[SYNC_STAGES-2:0], pins_raw[l]};
    end
    assign pins_s[l] = chain[SYNC_STAGES-1];
  end

  assign scl_s = pins_s[1];
  assign sda_s = pins_s[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;

  AST_EVENTS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_ev, stop_ev, scl_rise, scl_fall})); // R11

  AST_CONDITION_NEEDS_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev || stop_ev) |-> $past(scl_s)); // R11

endmodule

// File: rtl/i2c_tgt_buffers.sv
module i2c_tgt_buffers #(
  parameter int DEPTH = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_en,
  input  logic [IDX_W-1:0] host_wr_idx,
  input  logic [7:0]       host_wr_byte,
  input  logic [IDX_W-1:0] eng_rd_idx,
  output logic [7:0]       eng_rd_byte,
  input  logic             eng_wr_en,
  input  logic [IDX_W-1:0] eng_wr_idx,
  input  logic [7:0]       eng_wr_byte,
  input  logic [IDX_W-1:0] host_rd_idx,
  output logic [7:0]       host_rd_byte
);

  localparam logic [IDX_W:0] DEPTH_X = (IDX_W + 1)'(DEPTH);

  logic [7:0] tx_mem [DEPTH];
  logic [7:0] rx_mem [DEPTH];

  function automatic logic in_range(input logic [IDX_W-1:0] idx);
    return {1'b0, idx} < DEPTH_X;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tx_mem[i] <= '0;
    end else if (host_wr_en && in_range(host_wr_idx)) begin
      tx_mem[host_wr_idx] <= host_wr_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) rx_mem[i] <= '0;
    end else if (eng_wr_en && in_range(eng_wr_idx)) begin
      rx_mem[eng_wr_idx] <= eng_wr_byte;
    end
  end

  assign eng_rd_byte  = in_range(eng_rd_idx)  ? tx_mem[eng_rd_idx]  : 8'hFF;
  assign host_rd_byte = in_range(host_rd_idx) ? rx_mem[host_rd_idx] : 8'h00;

  AST_ENGINE_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    eng_wr_en |-> in_range(eng_wr_idx)); // R4

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR = 7'h55,
  parameter int         DEPTH    = 16,
  parameter int         HOLD_CYC = 3,
  parameter int         IDX_W    = 4,
  parameter int         CNT_W    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  output logic [IDX_W-1:0] tx_rd_idx,
  input  logic [7:0]       tx_rd_byte,
  output logic             rx_we,
  output logic [IDX_W-1:0] rx_wr_idx,
  output logic [7:0]       rx_wr_byte,
  output logic             sda_drive_low,
  output tgt_status_e      stat_code,
  output logic [CNT_W-1:0] stat_count,
  output logic             stat_done
);

  localparam int               HOLD_W = $clog2(HOLD_CYC + 1);
  localparam logic [CNT_W-1:0] LIMIT  = CNT_W'(DEPTH);
  localparam logic [HOLD_W:0]  SAT    = (HOLD_W + 1)'(HOLD_CYC + 1);

  tgt_mode_e        mode;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic [7:0]       txbyte;
  logic [CNT_W-1:0] count;
  logic             rw_q;
  logic             ovf_q;
  logic             active_q;
  logic [HOLD_W-1:0] hold_cnt;
  logic             pend_q;
  logic             drive_q;
  logic             plan;
  logic [2:0]       bit_sel;
  logic [HOLD_W:0]  since_fall;

  // Named internal events
  logic byte_ev, bit_ev, at_limit, tx_last, addr_ok, drive_upd;
  assign byte_ev   = scl_rise && (mode != M_IDLE) && (bitcnt == 4'd8);
  assign bit_ev    = scl_rise && (mode != M_IDLE) && (bitcnt != 4'd8);
  assign at_limit  = (count == LIMIT);
  assign tx_last   = ((count + CNT_W'(1)) == LIMIT);
  assign addr_ok   = addr_hit(shreg, OWN_ADDR);
  assign drive_upd = (hold_cnt == HOLD_W'(1));
  assign bit_sel   = 3'(4'd7 - bitcnt);

  // SDA value for the SCL high phase that follows the current low phase
  always_comb begin
    case (mode)
      M_ADDR:  plan = (bitcnt == 4'd8) && addr_ok;
      M_RX:    plan = (bitcnt == 4'd8);
      M_TX:    plan = (bitcnt != 4'd8) && !txbyte[bit_sel];
      default: plan = 1'b0;
    endcase
  end

  assign tx_rd_idx     = (mode == M_TX) ? IDX_W'(count + CNT_W'(1)) : '0;
  assign rx_we         = byte_ev && (mode == M_RX) && !at_limit;
  assign rx_wr_idx     = IDX_W'(count);
  assign rx_wr_byte    = shreg;
  assign sda_drive_low = drive_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode       <= M_IDLE;
      bitcnt     <= '0;
      shreg      <= '0;
      txbyte     <= '0;
      count      <= '0;
      rw_q       <= 1'b0;
      ovf_q      <= 1'b0;
      active_q   <= 1'b0;
      hold_cnt   <= '0;
      pend_q     <= 1'b0;
      drive_q    <= 1'b0;
      stat_code  <= ST_BUSY;
      stat_count <= '0;
      stat_done  <= 1'b0;
    end else begin
      stat_done <= 1'b0;
      if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - HOLD_W'(1);
        if (drive_upd) drive_q <= pend_q;
      end
      if (scl_fall && (mode != M_IDLE)) begin
        hold_cnt <= HOLD_W'(HOLD_CYC);
        pend_q   <= plan;
      end
      if (start_ev) begin
        mode     <= M_ADDR;
        bitcnt   <= '0;
        active_q <= 1'b0;
      end else if (stop_ev) begin
        mode   <= M_IDLE;
        bitcnt <= '0;
        if (active_q) begin
          stat_code  <= outcome(ovf_q, rw_q, count != '0);
          stat_count <= count;
          stat_done  <= 1'b1;
          active_q   <= 1'b0;
        end
      end else if (bit_ev) begin
        bitcnt <= bitcnt + 4'd1;
        shreg  <= {shreg[6:0], sda_s};
      end else if (byte_ev) begin
        bitcnt <= '0;
        case (mode)
          M_ADDR: begin
            if (addr_ok) begin
              active_q   <= 1'b1;
              rw_q       <= shreg[0];
              ovf_q      <= 1'b0;
              count      <= '0;
              stat_code  <= ST_BUSY;
              stat_count <= '0;
              if (shreg[0]) begin
                mode   <= M_TX;
                txbyte <= tx_rd_byte;
              end else begin
                mode <= M_RX;
              end
            end else begin
              mode <= M_IDLE;
            end
          end
          M_RX: begin
            if (at_limit) ovf_q <= 1'b1;
            else          count <= count + CNT_W'(1);
          end
          M_TX: begin
            count <= count + CNT_W'(1);
            if (sda_s) begin
              mode <= M_DRAIN;
            end else if (tx_last) begin
              ovf_q <= 1'b1;
              mode  <= M_DRAIN;
            end else begin
              txbyte <= tx_rd_byte;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Cycles since the last synchronized SCL fall, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_fall <= SAT;
    else if (scl_fall)          since_fall <= '0;
    else if (since_fall != SAT) since_fall <= since_fall + 1'b1;
  end

  AST_DRIVE_AFTER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> (since_fall == (HOLD_W + 1)'(HOLD_CYC))); // R10

  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_drive_low) |-> !scl_s); // R10

  AST_COUNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    count <= LIMIT); // R4

  AST_RX_STORE_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    rx_we |-> (count < LIMIT)); // R4

  AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_done |=> !stat_done); // R8

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_IDLE && hold_cnt == '0) |-> !sda_drive_low); // R6

  AST_DRAIN_NO_DATA_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_DRAIN && scl_fall) |=> !pend_q); // R7

endmodule

// File: rtl/i2c_buffered_target.sv
module i2c_buffered_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] OWN_ADDR    = 7'h55,
  parameter int         DEPTH       = 16,
  parameter int         HOLD_CYC    = 3,
  parameter int         SYNC_STAGES = 2,
  localparam int        IDX_W       = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int        CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_drive_low,
  input  logic             tx_wr_en,
  input  logic [IDX_W-1:0] tx_wr_idx,
  input  logic [7:0]       tx_wr_byte,
  input  logic [IDX_W-1:0] rx_rd_idx,
  output logic [7:0]       rx_rd_byte,
  output logic [1:0]       status_code,
  output logic [CNT_W-1:0] status_count,
  output logic             status_done
);

  logic             scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  logic [IDX_W-1:0] tx_rd_idx;
  logic [7:0]       tx_rd_byte;
  logic             rx_we;
  logic [IDX_W-1:0] rx_wr_idx;
  logic [7:0]       rx_wr_byte;
  tgt_status_e      stat_code;

  i2c_tgt_sampler #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_sampler (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  i2c_tgt_engine #(
    .OWN_ADDR (OWN_ADDR),
    .DEPTH    (DEPTH),
    .HOLD_CYC (HOLD_CYC),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W)
  ) u_engine (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_s         (scl_s),
    .sda_s         (sda_s),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev),
    .tx_rd_idx     (tx_rd_idx),
    .tx_rd_byte    (tx_rd_byte),
    .rx_we         (rx_we),
    .rx_wr_idx     (rx_wr_idx),
    .rx_wr_byte    (rx_wr_byte),
    .sda_drive_low (sda_drive_low),
    .stat_code     (stat_code),
    .stat_count    (status_count),
    .stat_done     (status_done)
  );

  i2c_tgt_buffers #(
    .DEPTH (DEPTH),
    .IDX_W (IDX_W)
  ) u_buffers (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (tx_wr_en),
    .host_wr_idx  (tx_wr_idx),
    .host_wr_byte (tx_wr_byte),
    .eng_rd_idx   (tx_rd_idx),
    .eng_rd_byte  (tx_rd_byte),
    .eng_wr_en    (rx_we),
    .eng_wr_idx   (rx_wr_idx),
    .eng_wr_byte  (rx_wr_byte),
    .host_rd_idx  (rx_rd_idx),
    .host_rd_byte (rx_rd_byte)
  );

  assign status_code = stat_code;

endmodule

// File: tb/i2c_buffered_target_bench.sv
module i2c_buffered_target_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int IDX_W      = 4;
  localparam int CNT_W      = 5;
  localparam int HALF       = 30;
  localparam int GAP        = 4;
  localparam int WATCHDOG   = 150000;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m;
  logic sda_m_low;
  logic dut_low;
  logic sda_line;
  logic tx_wr_en;
  logic [IDX_W-1:0] tx_wr_idx;
  logic [7:0] tx_wr_byte;
  logic [IDX_W-1:0] rx_rd_idx;
  logic [7:0] rx_rd_byte;
  logic [1:0] status_code;
  logic [CNT_W-1:0] status_count;
  logic status_done;

  int n_cmp = 0;
  int n_bad = 0;
  int done_cnt = 0;
  int unstable = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign sda_line = !(sda_m_low || dut_low);

  i2c_buffered_target u_i2c_buffered_target (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl_m),
    .sda_i         (sda_line),
    .sda_drive_low (dut_low),
    .tx_wr_en      (tx_wr_en),
    .tx_wr_idx     (tx_wr_idx),
    .tx_wr_byte    (tx_wr_byte),
    .rx_rd_idx     (rx_rd_idx),
    .rx_rd_byte    (rx_rd_byte),
    .status_code   (status_code),
    .status_count  (status_count),
    .status_done   (status_done)
  );

  always @(negedge clk) if (rst_n && status_done) done_cnt++;

  function automatic logic [7:0] tx_pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    waitc(GAP);
    sda_m_low = !b;
    waitc(HALF);
    scl_m = 1'b1;
    waitc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic read_bit(output logic b);
    logic s1;
    waitc(GAP);
    sda_m_low = 1'b0;
    waitc(HALF);
    scl_m = 1'b1;
    waitc(3);
    s1 = sda_line;
    waitc(HALF - 3);
    b = sda_line;
    if (s1 != b) unstable++;
    scl_m = 1'b0;
  endtask

  task automatic bus_start();
    waitc(HALF);
    sda_m_low = 1'b1;
    waitc(HALF);
    scl_m = 1'b0;
  endtask

  task automatic bus_stop();
    waitc(GAP);
    sda_m_low = 1'b1;
    waitc(HALF);
    scl_m = 1'b1;
    waitc(HALF);
    sda_m_low = 1'b0;
    waitc(10);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    read_bit(ack);
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] v);
    logic b;
    v = '0;
    for (int i = 0; i < 8; i++) begin
      read_bit(b);
      v = {v[6:0], b};
    end
    send_bit(!give_ack);
  endtask

  task automatic rx_peek(input int idx, output logic [7:0] v);
    rx_rd_idx = IDX_W'(idx);
    waitc(1);
    v = rx_rd_byte;
  endtask

  task automatic t_reset();
    check("R1 drive released", int'(dut_low), 0);
    check("R1 status code", int'(status_code), 0);
    check("R1 status count", int'(status_count), 0);
    check("R1 no done pulse", done_cnt, 0);
  endtask

  task automatic t_load_tx();
    for (int i = 0; i < DEPTH; i++) begin
      tx_wr_idx  = IDX_W'(i);
      tx_wr_byte = tx_pat(i);
      tx_wr_en   = 1'b1;
      waitc(1);
    end
    tx_wr_en = 1'b0;
    waitc(1);
  endtask

  task automatic t_write_basic();
    logic ack;
    logic [7:0] v;
    logic [7:0] data [3] = '{8'h12, 8'h34, 8'hC5};
    int d0 = done_cnt;
    bus_start();
    write_byte(8'hAA, ack);
    check("R2 address ack", int'(ack), 0);
    for (int i = 0; i < 3; i++) begin
      write_byte(data[i], ack);
      check("R3 data ack", int'(ack), 0);
    end
    bus_stop();
    check("R8 write done code", int'(status_code), 1);
    check("R8 write count", int'(status_count), 3);
    check("R8 R11 one done pulse", done_cnt - d0, 1);
    for (int i = 0; i < 3; i++) begin
      rx_peek(i, v);
      check("R3 stored byte", int'(v), int'(data[i]));
    end
  endtask

  task automatic t_wrong_addr();
    logic ack;
    logic [7:0] v;
    int d0 = done_cnt;
    bus_start();
    write_byte(8'h74, ack);
    check("R2 foreign address not acked", int'(ack), 1);
    write_byte(8'h99, ack);
    check("R2 foreign data not acked", int'(ack), 1);
    bus_stop();
    check("R2 status code kept", int'(status_code), 1);
    check("R2 status count kept", int'(status_count), 3);
    check("R2 no done pulse", done_cnt - d0, 0);
    rx_peek(0, v);
    check("R2 buffer untouched", int'(v), 8'h12);
  endtask

  task automatic t_write_overrun();
    logic ack;
    logic [7:0] v;
    int bad_acks = 0;
    bus_start();
    write_byte(8'hAA, ack);
    check("R2 address ack", int'(ack), 0);
    for (int i = 0; i < DEPTH + 2; i++) begin
      write_byte(8'(8'h40 + i), ack);
      if (ack) bad_acks++;
    end
    check("R4 all bytes acked", bad_acks, 0);
    bus_stop();
    check("R4 overrun code", int'(status_code), 3);
    check("R4 count capped", int'(status_count), DEPTH);
    rx_peek(0, v);
    check("R4 first entry kept", int'(v), 8'h40);
    rx_peek(DEPTH - 1, v);
    check("R4 last entry", int'(v), 8'h40 + DEPTH - 1);
  endtask

  task automatic t_read_nack();
    logic ack;
    logic [7:0] v;
    int d0 = done_cnt;
    bus_start();
    write_byte(8'hAB, ack);
    check("R2 read address ack", int'(ack), 0);
    for (int i = 0; i < 4; i++) begin
      read_byte(i < 3, v);
      check("R5 transmitted byte", int'(v), int'(tx_pat(i)));
    end
    read_byte(1'b0, v);
    check("R6 released after nack", int'(v), 8'hFF);
    bus_stop();
    check("R6 read done code", int'(status_code), 2);
    check("R6 count includes nacked", int'(status_count), 4);
    check("R8 one done pulse", done_cnt - d0, 1);
  endtask

  task automatic t_read_limit();
    logic ack;
    logic [7:0] v;
    int wrong = 0;
    bus_start();
    write_byte(8'hAB, ack);
    check("R2 read address ack", int'(ack), 0);
    for (int i = 0; i < DEPTH; i++) begin
      read_byte(1'b1, v);
      if (v != tx_pat(i)) wrong++;
    end
    check("R5 all buffer bytes sent", wrong, 0);
    read_byte(1'b0, v);
    check("R7 released at limit", int'(v), 8'hFF);
    bus_stop();
    check("R7 overrun code", int'(status_code), 3);
    check("R7 count", int'(status_count), DEPTH);
  endtask

  task automatic t_addr_only();
    logic ack;
    int d0 = done_cnt;
    bus_start();
    write_byte(8'hAA, ack);
    check("R9 address ack", int'(ack), 0);
    bus_stop();
    check("R9 busy code", int'(status_code), 0);
    check("R9 zero count", int'(status_count), 0);
    check("R9 done pulse", done_cnt - d0, 1);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    rst_n      = 1'b0;
    scl_m      = 1'b1;
    sda_m_low  = 1'b0;
    tx_wr_en   = 1'b0;
    tx_wr_idx  = '0;
    tx_wr_byte = '0;
    rx_rd_idx  = '0;
    waitc(5);
    rst_n = 1'b1;
    waitc(5);
    t_reset();
    t_load_tx();
    t_write_basic();
    t_wrong_addr();
    t_write_overrun();
    t_read_nack();
    t_read_limit();
    t_addr_only();
    check("R10 SDA stable while SCL high", unstable, 0);
    finish_run();
  end

  initial begin
    waitc(WATCHDOG);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

endmodule